// File: doc/BRIEF.md
# Multiprocessor Interrupt Routing Controller

This block collects interrupt levels from a parameterised set of sources and presents one level-sensitive IRQ line to each of several processor cores. Software reaches it over a simple 32-bit register bus with two windows. The global window holds a master switch, an enable port pair for shared sources and one routing word per source. The per-core window, selected by a core index on the bus, holds a mask port pair for that core's private sources, a raw cause view, an acknowledge register and a scratch task-priority register.

Sources numbered below `N_PRIV` are banked: each core has its own copy with its own mask. Source 0 of each bank is the OR of that core's inbound doorbell lines. Sources from `N_PRIV` upward are shared by all cores and are switched on and off globally. Enables and masks change when a source number is written to a set or clear port, so no read-modify-write is needed. A core's line rises when at least one source is pending, enabled or unmasked, routed to that core, and the master switch is on. The acknowledge register names the lowest such source.

Top module: `mirc_top`

## Requirements
- R1: After reset all IRQ lines are low, the master switch is off, every shared source is disabled, every private source is masked on every core, every routing word reads 0, and acknowledge reads 0x3ff.
- R2: Global offset 0x000: bit 0 is a read/write master switch, bits [11:2] read the number of implemented sources (`NUM_SRC`) and ignore writes, and other bits read 0.
- R3: Writing a shared source number (`N_PRIV` to `NUM_SRC`-1) in bits [9:0] to global offset 0x030 enables that source. Writing it to 0x034 disables it.
- R4: The routing word of source s sits at global offset 0x100+4*s. Bit c routes the source to core c's IRQ and bit 8+c holds that core's fast-interrupt route. Both are stored and read back, other bits read 0, and offsets for s at or above `NUM_SRC` read 0.
- R5: Per-core offset 0x048 masks, and 0x04C unmasks, the private source whose number is written in bits [9:0]. This acts only on the accessing core's bank.
- R6: Per-core offset 0x010 reads that core's raw private pending levels with bit n for source n. Bit 0 is the OR of that core's doorbell lines.
- R7: `irq_o[c]` is high exactly when some source is pending, enabled (shared) or unmasked on core c (private), has routing bit c set, and the master switch is on.
- R8: Per-core offset 0x044 returns in bits [9:0] the lowest-numbered source that qualifies for that core under R7, or 0x3ff when none does.
- R9: Per-core offset 0x040 is a 32-bit read/write register, separate for each core.
- R10: Writes to the enable ports with a number that is not a shared source, and writes to the mask ports with a number at or above `N_PRIV`, change nothing.
- R11: Reading acknowledge has no side effect. A source that drops its level stops qualifying at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_win | input | 1 | Window select: 0 global, 1 per-core |
| bus_core | input | CORE_W | Core whose per-core window is accessed |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |
| db_i | input | NUM_CORES*DB_W | Inbound doorbell levels, DB_W per core |
| priv_irq_i | input | NUM_CORES*(N_PRIV-1) | Private source levels 1..N_PRIV-1 per core |
| shr_irq_i | input | NUM_SRC-N_PRIV | Shared source levels, bit 0 is source N_PRIV |
| irq_o | output | NUM_CORES | Level IRQ to each core |

## Verification
The bench builds the block with two cores, 32 private sources, 40 sources in all and two doorbell lines per core. With only eight shared sources, every shared source can be pending and routed at once while only the top one, 39, is enabled. Source number 40 is then the first value out of range and can be tested at the enable ports. Two cores are enough to show that masks, routing bits, cause views and the task-priority scratch do not leak between banks.

// File: rtl/mirc_pkg.sv
package mirc_pkg;
   localparam int SRC_W = 10;

   localparam logic [11:0] OFS_CTRL     = 12'h000;
   localparam logic [11:0] OFS_EN_SET   = 12'h030;
   localparam logic [11:0] OFS_EN_CLR   = 12'h034;
   localparam logic [11:0] OFS_CTL_BASE = 12'h100;

   localparam logic [11:0] OFS_CAUSE    = 12'h010;
   localparam logic [11:0] OFS_PRIO     = 12'h040;
   localparam logic [11:0] OFS_ACK      = 12'h044;
   localparam logic [11:0] OFS_MSK_SET  = 12'h048;
   localparam logic [11:0] OFS_MSK_CLR  = 12'h04C;

   localparam logic [SRC_W-1:0] ACK_NONE = 10'h3FF;
endpackage

// File: rtl/mirc_glob.sv
module mirc_glob
   import mirc_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int NUM_SRC   = 64,
   parameter int N_PRIV    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [11:0]                   addr_i,
   input  logic [15:0]                   wdata_i,
   output logic [31:0]                   rdata_o,
   output logic                          glb_en_o,
   output logic [NUM_SRC-1:0]            src_en_o,
   output logic [NUM_CORES*NUM_SRC-1:0]  route_o
);
   localparam int          CMASK    = (1 << NUM_CORES) - 1;
   localparam logic [15:0] CTL_KEEP = 16'(CMASK | (CMASK << 8));

   logic [SRC_W-1:0] wr_idx;
   logic [SRC_W-1:0] ctl_idx;
   logic             idx_shared;
   logic             set_hit;
   logic             clr_hit;
   logic             ctl_hit;
   logic             glb_en_q;
   logic [15:0]      ctl_q [NUM_SRC];

   assign wr_idx     = wdata_i[SRC_W-1:0];
   assign idx_shared = (wr_idx >= SRC_W'(N_PRIV)) && (wr_idx < SRC_W'(NUM_SRC));
   assign set_hit    = wr_i && (addr_i == OFS_EN_SET) && idx_shared;
   assign clr_hit    = wr_i && (addr_i == OFS_EN_CLR) && idx_shared;
   assign ctl_idx    = SRC_W'((addr_i - OFS_CTL_BASE) >> 2);
   assign ctl_hit    = (addr_i >= OFS_CTL_BASE) && (addr_i[1:0] == 2'b00)
                       && (ctl_idx < SRC_W'(NUM_SRC));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         glb_en_q <= 1'b0;
      else if (wr_i && addr_i == OFS_CTRL)
         glb_en_q <= wdata_i[0];

   assign glb_en_o = glb_en_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [15:0] word_q;

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)
            word_q <= '0;
         else if (wr_i && ctl_hit && ctl_idx == SRC_W'(s))
            word_q <= wdata_i & CTL_KEEP;

      assign ctl_q[s] = word_q;

      for (genvar c = 0; c < NUM_CORES; c++) begin : g_rt
         assign route_o[c*NUM_SRC+s] = word_q[c];
      end

      if (s < N_PRIV) begin : g_banked
         assign src_en_o[s] = 1'b0;
      end else begin : g_shared
         logic en_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               en_q <= 1'b0;
            else if (set_hit && wr_idx == SRC_W'(s))
               en_q <= 1'b1;
            else if (clr_hit && wr_idx == SRC_W'(s))
               en_q <= 1'b0;
         assign src_en_o[s] = en_q;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == OFS_CTRL)
         rdata_o = {20'b0, SRC_W'(NUM_SRC), 1'b0, glb_en_q};
      else if (ctl_hit)
         for (int s = 0; s < NUM_SRC; s++)
            if (ctl_idx == SRC_W'(s))
               rdata_o = {16'b0, ctl_q[s]};
   end
endmodule

// File: rtl/mirc_core.sv
module mirc_core
   import mirc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int N_PRIV  = 32,
   parameter int DB_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_i,
   input  logic [11:0]            addr_i,
   input  logic [31:0]            wdata_i,
   output logic [31:0]            rdata_o,
   input  logic                   glb_en_i,
   input  logic [NUM_SRC-1:0]     src_en_i,
   input  logic [NUM_SRC-1:0]     route_i,
   input  logic [N_PRIV-2:0]      priv_lvl_i,
   input  logic [DB_W-1:0]        db_i,
   input  logic [NUM_SRC-N_PRIV-1:0] shr_lvl_i,
   output logic                   irq_o,
   output logic [SRC_W-1:0]       ack_o
);
   logic [N_PRIV-1:0]  mask_q;
   logic [31:0]        prio_q;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] gate;
   logic [NUM_SRC-1:0] qual;
   logic [SRC_W-1:0]   wr_idx;
   logic               idx_priv;

   assign wr_idx   = wdata_i[SRC_W-1:0];
   assign idx_priv = wr_idx < SRC_W'(N_PRIV);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mask_q <= '1;
         prio_q <= '0;
      end else if (wr_i) begin
         if (addr_i == OFS_PRIO)
            prio_q <= wdata_i;
         for (int s = 0; s < N_PRIV; s++) begin
            if (idx_priv && wr_idx == SRC_W'(s) && addr_i == OFS_MSK_SET)
               mask_q[s] <= 1'b1;
            if (idx_priv && wr_idx == SRC_W'(s) && addr_i == OFS_MSK_CLR)
               mask_q[s] <= 1'b0;
         end
      end

   assign pend = {shr_lvl_i, priv_lvl_i, |db_i};
   assign gate = {src_en_i[NUM_SRC-1:N_PRIV], ~mask_q};
   assign qual = pend & route_i & gate & {NUM_SRC{glb_en_i}};
   assign irq_o = |qual;

   always_comb begin
      ack_o = ACK_NONE;
      for (int s = NUM_SRC - 1; s >= 0; s--)
         if (qual[s])
            ack_o = SRC_W'(s);
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         OFS_CAUSE: rdata_o = 32'(pend[N_PRIV-1:0]);
         OFS_PRIO:  rdata_o = prio_q;
         OFS_ACK:   rdata_o = {22'b0, ack_o};
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/mirc_top.sv
module mirc_top
   import mirc_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int NUM_SRC   = 64,
   parameter int N_PRIV    = 32,
   parameter int DB_W      = 4,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int PRIV_IN  = N_PRIV - 1,
   localparam int SHR_IN   = NUM_SRC - N_PRIV
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic                        bus_win,
   input  logic [CORE_W-1:0]           bus_core,
   input  logic [11:0]                 bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   input  logic [NUM_CORES*DB_W-1:0]   db_i,
   input  logic [NUM_CORES*PRIV_IN-1:0] priv_irq_i,
   input  logic [SHR_IN-1:0]           shr_irq_i,
   output logic [NUM_CORES-1:0]        irq_o
);
   if (NUM_CORES < 1 || NUM_CORES > 8) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..8");
   end
   if (N_PRIV < 2 || N_PRIV > 32) begin : g_bad_priv
      $error("N_PRIV must lie in 2..32");
   end
   if (NUM_SRC <= N_PRIV || NUM_SRC > 1023) begin : g_bad_src
      $error("NUM_SRC must exceed N_PRIV and stay below 1024");
   end
   if (DB_W < 1) begin : g_bad_db
      $error("DB_W must be at least 1");
   end

   logic                         glb_en;
   logic [NUM_SRC-1:0]           src_en;
   logic [NUM_CORES*NUM_SRC-1:0] route;
   logic [31:0]                  glb_rd;
   logic [31:0]                  core_rd [NUM_CORES];
   logic [NUM_CORES*SRC_W-1:0]   ack_flat;

   mirc_glob #(
      .NUM_CORES (NUM_CORES),
      .NUM_SRC   (NUM_SRC),
      .N_PRIV    (N_PRIV)
   ) u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (bus_wr && !bus_win),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata[15:0]),
      .rdata_o  (glb_rd),
      .glb_en_o (glb_en),
      .src_en_o (src_en),
      .route_o  (route)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      mirc_core #(
         .NUM_SRC (NUM_SRC),
         .N_PRIV  (N_PRIV),
         .DB_W    (DB_W)
      ) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (bus_wr && bus_win && bus_core == CORE_W'(c)),
         .addr_i     (bus_addr),
         .wdata_i    (bus_wdata),
         .rdata_o    (core_rd[c]),
         .glb_en_i   (glb_en),
         .src_en_i   (src_en),
         .route_i    (route[c*NUM_SRC +: NUM_SRC]),
         .priv_lvl_i (priv_irq_i[c*PRIV_IN +: PRIV_IN]),
         .db_i       (db_i[c*DB_W +: DB_W]),
         .shr_lvl_i  (shr_irq_i),
         .irq_o      (irq_o[c]),
         .ack_o      (ack_flat[c*SRC_W +: SRC_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (!bus_win)
            bus_rdata = glb_rd;
         else
            for (int c = 0; c < NUM_CORES; c++)
               if (bus_core == CORE_W'(c))
                  bus_rdata = core_rd[c];
      end
   end
endmodule

// File: rtl/mirc_chk.sv
module mirc_chk
   import mirc_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int NUM_SRC   = 64,
   parameter int N_PRIV    = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic                       bus_rd,
   input logic                       bus_win,
   input logic [11:0]                bus_addr,
   input logic [31:0]                bus_wdata,
   input logic [31:0]                bus_rdata,
   input logic                       glb_en,
   input logic [NUM_SRC-1:0]         src_en,
   input logic [NUM_CORES-1:0]       irq_o,
   input logic [NUM_CORES*SRC_W-1:0] ack_flat
);
   // R7: master switch off keeps every line low
   a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> irq_o == '0);

   // R2: source count field on a global control read
   a_r2_count_field: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_win && bus_addr == OFS_CTRL)
         |-> bus_rdata[11:2] == SRC_W'(NUM_SRC));

   // R10: out-of-range enable port writes leave enables untouched
   a_r10_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_win && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)
         && bus_wdata[SRC_W-1:0] >= SRC_W'(NUM_SRC))
         |=> $stable(src_en));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      // R8: a raised line always names a real source
      a_r8_ack_valid: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[c] |-> ack_flat[c*SRC_W +: SRC_W] < SRC_W'(NUM_SRC));
      // R8: a low line always reads the idle code
      a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_o[c] |-> ack_flat[c*SRC_W +: SRC_W] == ACK_NONE);
   end
endmodule

bind mirc_top mirc_chk #(
   .NUM_CORES (NUM_CORES),
   .NUM_SRC   (NUM_SRC),
   .N_PRIV    (N_PRIV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_win   (bus_win),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .glb_en    (glb_en),
   .src_en    (src_en),
   .irq_o     (irq_o),
   .ack_flat  (ack_flat)
);

// File: tb/sim_mirc_top.sv
module sim_mirc_top;
   localparam int CLK_P = 10;
   localparam int NC    = 2;
   localparam int NS    = 40;
   localparam int NP    = 32;
   localparam int DBW   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic              bus_win = 1'b0;
   logic [0:0]        bus_core = '0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NC*DBW-1:0] db_i = '0;
   logic [NC*(NP-1)-1:0] priv_irq_i = '0;
   logic [NS-NP-1:0]  shr_irq_i = '0;
   logic [NC-1:0]     irq_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   mirc_top #(.NUM_CORES(NC), .NUM_SRC(NS), .N_PRIV(NP), .DB_W(DBW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_win(bus_win), .bus_core(bus_core), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .db_i(db_i),
      .priv_irq_i(priv_irq_i), .shr_irq_i(shr_irq_i), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr_g(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_win = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_c(input int c, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_win = 1'b1; bus_core = 1'(c); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_g(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_win = 1'b0; bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic rd_c(input int c, input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_win = 1'b1; bus_core = 1'(c); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   function automatic logic [11:0] ctl_ofs(input int s);
      return 12'(12'h100 + 4*s);
   endfunction

   function automatic int pidx(input int c, input int s);
      return c*(NP-1) + s - 1;
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd_g(12'h000, d);      chk("R1 ctrl after reset", d, 32'h0A0);
      chk("R1 irq after reset", 32'(irq_o), 32'h0);
      rd_c(0, 12'h044, d);   chk("R1 ack core0 idle", d, 32'h3FF);
      rd_g(ctl_ofs(35), d);  chk("R1 routing word zero", d, 32'h0);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      wr_g(12'h000, 32'hFFFF_FFFF);
      rd_g(12'h000, d);      chk("R2 ctrl count read-only", d, 32'h0A1);
      wr_g(12'h000, 32'h0);
      rd_g(12'h000, d);      chk("R2 ctrl switch off", d, 32'h0A0);
      wr_g(12'h000, 32'h1);
   endtask

   task automatic t_route();
      logic [31:0] d;
      wr_g(ctl_ofs(33), 32'hFFFF_FFFF);
      rd_g(ctl_ofs(33), d);  chk("R4 routing bits kept", d, 32'h0303);
      wr_g(ctl_ofs(39), 32'h0102);
      rd_g(ctl_ofs(39), d);  chk("R4 routing mixed", d, 32'h0102);
      rd_g(ctl_ofs(40), d);  chk("R4 beyond last source", d, 32'h0);
   endtask

   task automatic t_shared();
      logic [31:0] d;
      wr_g(ctl_ofs(33), 32'h1);
      shr_irq_i[1] = 1'b1;
      #1 chk("R3 disabled source quiet", 32'(irq_o), 32'h0);
      wr_g(12'h030, 32'd33);
      #1 chk("R7 shared routed to core0", 32'(irq_o), 32'h1);
      rd_c(0, 12'h044, d);   chk("R8 ack core0 shared", d, 32'd33);
      rd_c(1, 12'h044, d);   chk("R8 ack core1 unrouted", d, 32'h3FF);
      wr_g(12'h034, 32'd33);
      #1 chk("R3 clear-enable", 32'(irq_o), 32'h0);
      shr_irq_i = '0;
   endtask

   task automatic t_range();
      logic [31:0] d;
      for (int s = NP; s < NS; s++) wr_g(ctl_ofs(s), 32'h1);
      shr_irq_i = '1;
      wr_g(12'h030, 32'd40);
      wr_g(12'h030, 32'h3FF);
      #1 chk("R10 set-enable out of range", 32'(irq_o), 32'h0);
      wr_g(ctl_ofs(5), 32'h1);
      priv_irq_i[pidx(0, 5)] = 1'b1;
      wr_g(12'h030, 32'd5);
      #1 chk("R10 set-enable private number", 32'(irq_o), 32'h0);
      wr_g(12'h030, 32'd39);
      rd_c(0, 12'h044, d);   chk("R8 ack only enabled source", d, 32'd39);
      wr_c(0, 12'h048, 32'd39);
      #1 chk("R10 mask port shared number", 32'(irq_o), 32'h1);
      wr_g(12'h034, 32'd45);
      #1 chk("R10 clear-enable out of range", 32'(irq_o), 32'h1);
      wr_g(12'h034, 32'd39);
      #1 chk("R3 clear-enable top source", 32'(irq_o), 32'h0);
      shr_irq_i = '0;
      priv_irq_i = '0;
      wr_g(ctl_ofs(5), 32'h0);
   endtask

   task automatic t_priv();
      logic [31:0] d;
      priv_irq_i[pidx(1, 3)] = 1'b1;
      wr_g(ctl_ofs(3), 32'h2);
      #1 chk("R1 private masked at reset", 32'(irq_o), 32'h0);
      wr_c(1, 12'h04C, 32'd3);
      #1 chk("R5 unmask core1", 32'(irq_o), 32'h2);
      rd_c(1, 12'h044, d);   chk("R8 ack core1 private", d, 32'd3);
      wr_c(0, 12'h04C, 32'd3);
      priv_irq_i[pidx(0, 3)] = 1'b1;
      #1 chk("R7 core0 not routed", 32'(irq_o), 32'h2);
      wr_g(ctl_ofs(3), 32'h3);
      #1 chk("R7 both cores routed", 32'(irq_o), 32'h3);
      wr_c(1, 12'h048, 32'd3);
      #1 chk("R5 mask core1 only", 32'(irq_o), 32'h1);
      wr_c(0, 12'h048, 32'd40);
      #1 chk("R10 mask port beyond private", 32'(irq_o), 32'h1);
      priv_irq_i = '0;
      wr_c(0, 12'h048, 32'd3);
      wr_g(ctl_ofs(3), 32'h0);
   endtask

   task automatic t_cause();
      logic [31:0] d;
      db_i[1] = 1'b1;
      priv_irq_i[pidx(0, 7)] = 1'b1;
      priv_irq_i[pidx(1, 31)] = 1'b1;
      rd_c(0, 12'h010, d);   chk("R6 cause core0", d, 32'h81);
      rd_c(1, 12'h010, d);   chk("R6 cause core1", d, 32'h8000_0000);
      db_i = '0;
      priv_irq_i = '0;
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr_g(ctl_ofs(0), 32'h1);
      wr_g(ctl_ofs(7), 32'h1);
      wr_g(ctl_ofs(33), 32'h1);
      wr_c(0, 12'h04C, 32'd0);
      wr_c(0, 12'h04C, 32'd7);
      wr_g(12'h030, 32'd33);
      db_i[0] = 1'b1;
      priv_irq_i[pidx(0, 7)] = 1'b1;
      shr_irq_i[1] = 1'b1;
      rd_c(0, 12'h044, d);   chk("R8 lowest is doorbell", d, 32'd0);
      db_i = '0;
      rd_c(0, 12'h044, d);   chk("R8 next private", d, 32'd7);
      rd_c(0, 12'h044, d);   chk("R11 ack read keeps source", d, 32'd7);
      priv_irq_i = '0;
      rd_c(0, 12'h044, d);   chk("R8 then shared", d, 32'd33);
      shr_irq_i = '0;
      rd_c(0, 12'h044, d);   chk("R11 level drop idles ack", d, 32'h3FF);
      chk("R11 level drop lowers irq", 32'(irq_o), 32'h0);
   endtask

   task automatic t_glob();
      logic [31:0] d;
      shr_irq_i[1] = 1'b1;
      #1 chk("R7 qualifying shared", 32'(irq_o), 32'h1);
      wr_g(12'h000, 32'h0);
      #1 chk("R7 switch off quiet", 32'(irq_o), 32'h0);
      rd_c(0, 12'h044, d);   chk("R8 switch off idle ack", d, 32'h3FF);
      wr_g(12'h000, 32'h1);
      #1 chk("R7 switch on again", 32'(irq_o), 32'h1);
      shr_irq_i = '0;
   endtask

   task automatic t_ctp();
      logic [31:0] d;
      wr_c(0, 12'h040, 32'hDEAD_BEEF);
      wr_c(1, 12'h040, 32'h1234_5678);
      rd_c(0, 12'h040, d);   chk("R9 priority core0", d, 32'hDEAD_BEEF);
      rd_c(1, 12'h040, d);   chk("R9 priority core1", d, 32'h1234_5678);
   endtask

   initial begin
      #(CLK_P*100000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_route();
      t_shared();
      t_range();
      t_priv();
      t_cause();
      t_prio();
      t_glob();
      t_ctp();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule